// File: doc/BRIEF.md
# Commit-Stage Event Arbiter

This block sits where instructions retire in a simple in-order core. In each cycle with a valid retirement it receives four things: the retiring instruction's address, its sequential successor, any taken control-transfer target, and the event requests raised against that instruction. The requests can be a bank of fault lines, one trap, one abort and one maskable external interrupt. The block picks one event by fixed priority. In the same cycle it tells the register file whether the instruction's results may be written back. One cycle later it reports the event's class, vector number, the return address to save and whether the interrupted code can resume.

The retirement stream is valid-only. A retiring instruction cannot be held back, so the block has no ready output and accepts every valid beat. Events are evaluated only on valid beats, and a level-held interrupt request that loses arbitration is simply seen again at a later boundary. A one-instruction interrupt shadow follows any committed stack-segment load. A repeat-prefixed instruction that ends an iteration is an interrupt boundary whose return address points back at the instruction itself.

Top module: `evc_commit_arbiter`

## Requirements
- R1: A fault (any bit of `fault_req` on a valid beat, no abort) drives `commit_en` low in that cycle. One cycle later it gives `take_event`=1, `event_class`=0, `saved_pc` = the retiring address and `restartable`=1.
- R2: Fault line i carries vector FAULT_VEC_BASE+i (default base 0). When several fault lines are set, the lowest index is reported.
- R3: A trap with no taken transfer keeps `commit_en` high. It reports `event_class`=1, vector `trap_vec`, `restartable`=1 and `saved_pc` = the sequential next address.
- R4: A trap on an instruction whose control transfer is taken saves the transfer target instead of the sequential next address.
- R5: An abort drives `commit_en` low and reports `event_class`=2, vector `abort_vec`, `restartable`=0 and `saved_pc` = the retiring address.
- R6: An accepted interrupt reports `event_class`=3, vector `irq_vec` and `restartable`=1, with `commit_en` high. `saved_pc` is the transfer target if a transfer was taken, else the sequential next address.
- R7: When `rep_iter` marks the end of a repeat iteration, an accepted interrupt saves the retiring instruction's own address.
- R8: After a committed retirement with `ret_loads_ss`=1, the next retired instruction cannot take the interrupt. The shadow clears after that one retirement whether or not it raised an event.
- R9: Priority is abort, then fault, then trap, then interrupt; exactly one event is reported per beat.
- R10: With `irq_en`=0 the interrupt request has no effect. Neither the enable flag nor the shadow blocks faults or traps.
- R11: `take_event` is high only in the cycle after a valid beat that raised an accepted event. With `ret_valid`=0, `commit_en` is 0.
- R12: After reset `take_event`, `event_class`, `event_vec`, `saved_pc` and `restartable` are 0 and no shadow is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | A retirement beat is present |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_next_pc | input | 32 | Sequential successor address |
| ret_xfer_taken | input | 1 | The instruction took a control transfer |
| ret_xfer_target | input | 32 | Destination of the taken transfer |
| ret_loads_ss | input | 1 | The instruction loads the stack-segment register |
| rep_iter | input | 1 | Beat ends one iteration of a repeat-prefixed instruction |
| fault_req | input | 8 | Fault lines, line i maps to vector FAULT_VEC_BASE+i |
| trap_req | input | 1 | Trap raised after the instruction completes |
| trap_vec | input | 8 | Trap vector |
| abort_req | input | 1 | Abort request |
| abort_vec | input | 8 | Abort vector |
| irq_req | input | 1 | Maskable external interrupt request (level) |
| irq_vec | input | 8 | Interrupt vector |
| irq_en | input | 1 | Interrupt-enable flag |
| commit_en | output | 1 | Results of the retiring instruction may be written |
| take_event | output | 1 | One-cycle event report |
| event_class | output | 2 | 0 fault, 1 trap, 2 abort, 3 interrupt |
| event_vec | output | 8 | Vector number |
| saved_pc | output | 32 | Return address to save |
| restartable | output | 1 | Interrupted code can resume |

## Verification
A trap and a pending interrupt can fall on the same retirement. So can an interrupt and the beat just after a stack-segment load. Random stimulus raises all requests at independent rates, and directed beats force a trap on a taken branch with the interrupt asserted, and an interrupt on the instruction that follows a stack-segment load. A bench model that keeps its own copy of the shadow judges each beat: the trap must win and save the branch target, the shadowed interrupt must produce no event, and the next beat must accept it.

// File: rtl/evc_pkg.sv
`timescale 1ns/1ps
package evc_pkg;
  typedef enum logic [1:0] {
    EV_FAULT = 2'd0,
    EV_TRAP  = 2'd1,
    EV_ABORT = 2'd2,
    EV_IRQ   = 2'd3
  } ev_class_e;
endpackage

// File: rtl/evc_fault_pick.sv
`timescale 1ns/1ps
module evc_fault_pick #(
  parameter int NF   = 8,
  parameter int VW   = 8,
  parameter int BASE = 0
) (
  input  logic [NF-1:0] req,
  output logic          any,
  output logic [VW-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (req[i]) vec = VW'(BASE + i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/evc_irq_gate.sv
`timescale 1ns/1ps
module evc_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_valid,
  input  logic commit_en,
  input  logic ret_loads_ss,
  input  logic irq_req,
  input  logic irq_en,
  output logic irq_ok,
  output logic shadow_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else if (ret_valid) shadow_q <= ret_loads_ss & commit_en;
  end

  assign irq_ok = ret_valid & irq_req & irq_en & ~shadow_q;

  p_shadow_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_q |-> !irq_ok);
  p_ie_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_ok);
  p_shadow_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q && ret_valid && !ret_loads_ss) |=> !shadow_q);
endmodule

// File: rtl/evc_ret_sel.sv
`timescale 1ns/1ps
module evc_ret_sel
  import evc_pkg::*;
#(
  parameter int AW = 32
) (
  input  ev_class_e     cls,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] next_pc,
  input  logic          xfer_taken,
  input  logic [AW-1:0] xfer_target,
  input  logic          rep_iter,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] after_pc;
  assign after_pc = xfer_taken ? xfer_target : next_pc;

  always_comb begin
    unique case (cls)
      EV_FAULT: pc = ret_pc;
      EV_ABORT: pc = ret_pc;
      EV_TRAP:  pc = after_pc;
      EV_IRQ:   pc = rep_iter ? ret_pc : after_pc;
      default:  pc = ret_pc;
    endcase
  end
endmodule

// File: rtl/evc_commit_arbiter.sv
`timescale 1ns/1ps
module evc_commit_arbiter
  import evc_pkg::*;
#(
  parameter int AW             = 32,
  parameter int VW             = 8,
  parameter int NF             = 8,
  parameter int FAULT_VEC_BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] ret_next_pc,
  input  logic          ret_xfer_taken,
  input  logic [AW-1:0] ret_xfer_target,
  input  logic          ret_loads_ss,
  input  logic          rep_iter,
  input  logic [NF-1:0] fault_req,
  input  logic          trap_req,
  input  logic [VW-1:0] trap_vec,
  input  logic          abort_req,
  input  logic [VW-1:0] abort_vec,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic          irq_en,
  output logic          commit_en,
  output logic          take_event,
  output logic [1:0]    event_class,
  output logic [VW-1:0] event_vec,
  output logic [AW-1:0] saved_pc,
  output logic          restartable
);
  logic          flt_any;
  logic [VW-1:0] flt_vec;
  logic          irq_ok;
  logic          shadow_q;
  logic          ev_hit;
  ev_class_e     ev_cls;
  logic [VW-1:0] ev_vec;
  logic [AW-1:0] ev_pc;

  evc_fault_pick #(.NF(NF), .VW(VW), .BASE(FAULT_VEC_BASE)) u_fpick (
    .req (fault_req),
    .any (flt_any),
    .vec (flt_vec)
  );

  assign commit_en = ret_valid & ~abort_req & ~flt_any;

  evc_irq_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid    (ret_valid),
    .commit_en    (commit_en),
    .ret_loads_ss (ret_loads_ss),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .irq_ok       (irq_ok),
    .shadow_q     (shadow_q)
  );

  always_comb begin
    ev_hit = ret_valid;
    ev_cls = EV_IRQ;
    ev_vec = irq_vec;
    if (abort_req) begin
      ev_cls = EV_ABORT;
      ev_vec = abort_vec;
    end else if (flt_any) begin
      ev_cls = EV_FAULT;
      ev_vec = flt_vec;
    end else if (trap_req) begin
      ev_cls = EV_TRAP;
      ev_vec = trap_vec;
    end else if (!irq_ok) begin
      ev_hit = 1'b0;
    end
  end

  evc_ret_sel #(.AW(AW)) u_rsel (
    .cls         (ev_cls),
    .ret_pc      (ret_pc),
    .next_pc     (ret_next_pc),
    .xfer_taken  (ret_xfer_taken),
    .xfer_target (ret_xfer_target),
    .rep_iter    (rep_iter),
    .pc          (ev_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_event  <= 1'b0;
      event_class <= 2'd0;
      event_vec   <= '0;
      saved_pc    <= '0;
      restartable <= 1'b0;
    end else begin
      take_event <= ev_hit;
      if (ev_hit) begin
        event_class <= ev_cls;
        event_vec   <= ev_vec;
        saved_pc    <= ev_pc;
        restartable <= (ev_cls != EV_ABORT);
      end
    end
  end

  p_fault_squash_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && |fault_req && !abort_req) |=>
      (take_event && event_class == 2'd0 && saved_pc == $past(ret_pc)));
  p_abort_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_event && event_class == 2'd2) |-> !restartable);
  p_no_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !take_event);
  p_trap_commits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && trap_req && !abort_req && !(|fault_req)) |-> commit_en);
endmodule

// File: tb/evc_commit_arbiter_tb.sv
`timescale 1ns/1ps
module evc_commit_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 0;
  logic [31:0] ret_pc = 0, ret_next_pc = 0, ret_xfer_target = 0;
  logic        ret_xfer_taken = 0, ret_loads_ss = 0, rep_iter = 0;
  logic [7:0]  fault_req = 0;
  logic        trap_req = 0, abort_req = 0, irq_req = 0, irq_en = 0;
  logic [7:0]  trap_vec = 0, abort_vec = 0, irq_vec = 0;
  logic        commit_en, take_event, restartable;
  logic [1:0]  event_class;
  logic [7:0]  event_vec;
  logic [31:0] saved_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_shadow = 0;

  always #2 clk = ~clk;

  evc_commit_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_next_pc(ret_next_pc), .ret_xfer_taken(ret_xfer_taken),
    .ret_xfer_target(ret_xfer_target), .ret_loads_ss(ret_loads_ss),
    .rep_iter(rep_iter), .fault_req(fault_req), .trap_req(trap_req),
    .trap_vec(trap_vec), .abort_req(abort_req), .abort_vec(abort_vec),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_en(irq_en),
    .commit_en(commit_en), .take_event(take_event),
    .event_class(event_class), .event_vec(event_vec),
    .saved_pc(saved_pc), .restartable(restartable)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int low_fault(input logic [7:0] f);
    for (int i = 7; i >= 0; i--) if (f[i]) low_fault = i;
  endfunction

  // one retirement beat: drive at negedge, check commit, then registered outputs
  task automatic beat();
    bit        e_take, e_commit, e_rst;
    int        e_cls;
    logic [7:0] e_vec;
    logic [31:0] e_pc, after;
    string     tag;
    after = ret_xfer_taken ? ret_xfer_target : ret_next_pc;
    e_commit = ret_valid && !abort_req && fault_req == 0;
    e_take = 1; e_rst = 1; e_cls = 3; e_vec = irq_vec; e_pc = rep_iter ? ret_pc : after;
    tag = rep_iter ? "R7" : "R6";
    if (!ret_valid) begin e_take = 0; tag = "R11"; end
    else if (abort_req) begin e_cls = 2; e_vec = abort_vec; e_pc = ret_pc; e_rst = 0; tag = "R5"; end
    else if (fault_req != 0) begin e_cls = 0; e_vec = 8'(low_fault(fault_req)); e_pc = ret_pc; tag = "R1"; end
    else if (trap_req) begin e_cls = 1; e_vec = trap_vec; e_pc = after; tag = ret_xfer_taken ? "R4" : "R3"; end
    else if (!irq_req) begin e_take = 0; tag = "R11"; end
    else if (!irq_en) begin e_take = 0; tag = "R10"; end
    else if (m_shadow) begin e_take = 0; tag = "R8"; end
    if (e_take && (irq_req || trap_req) && (abort_req || fault_req != 0)) tag = "R9";
    #1;
    chk(commit_en == e_commit, "R11 commit_en", 32'(commit_en), 32'(e_commit));
    @(posedge clk);
    if (ret_valid) m_shadow = ret_loads_ss && e_commit;
    #1;
    chk(take_event == e_take, tag, 32'(take_event), 32'(e_take));
    if (e_take) begin
      chk(event_class == 2'(e_cls), tag, 32'(event_class), 32'(e_cls));
      chk(event_vec == e_vec, (e_cls == 0) ? "R2" : tag, 32'(event_vec), 32'(e_vec));
      chk(saved_pc == e_pc, tag, saved_pc, e_pc);
      chk(restartable == e_rst, tag, 32'(restartable), 32'(e_rst));
    end
    @(negedge clk);
  endtask

  task automatic clear_in();
    ret_valid = 0; fault_req = 0; trap_req = 0; abort_req = 0; irq_req = 0;
    ret_loads_ss = 0; rep_iter = 0; ret_xfer_taken = 0; irq_en = 1;
  endtask

  task automatic set_pc(input logic [31:0] a);
    ret_pc = a; ret_next_pc = a + 4; ret_xfer_target = a ^ 32'h0000_8000;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    trap_vec = 8'd3; abort_vec = 8'd8; irq_vec = 8'd32;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(take_event == 0 && event_class == 0 && event_vec == 0 && saved_pc == 0 && restartable == 0,
        "R12", {event_vec, 6'd0, event_class, 14'd0, take_event, restartable}, 0);
    rst_n = 1;
    @(negedge clk);

    // R8: stack-segment load then interrupt -> shadowed, next beat accepted
    clear_in(); set_pc(32'h100); ret_valid = 1; ret_loads_ss = 1; beat();
    clear_in(); set_pc(32'h104); ret_valid = 1; irq_req = 1; beat();
    clear_in(); set_pc(32'h108); ret_valid = 1; irq_req = 1; beat();
    // R10: shadow does not block a trap
    clear_in(); set_pc(32'h200); ret_valid = 1; ret_loads_ss = 1; beat();
    clear_in(); set_pc(32'h204); ret_valid = 1; trap_req = 1; irq_req = 1; beat();
    // R4/R9: trap on taken branch with interrupt pending
    clear_in(); set_pc(32'h300); ret_valid = 1; trap_req = 1; irq_req = 1; ret_xfer_taken = 1; beat();
    // R2: several faults, lowest index wins
    clear_in(); set_pc(32'h400); ret_valid = 1; fault_req = 8'b1010_1100; trap_req = 1; beat();
    // R5/R9: abort over fault
    clear_in(); set_pc(32'h500); ret_valid = 1; abort_req = 1; fault_req = 8'h01; beat();
    // R7: interrupt at a repeat iteration end
    clear_in(); set_pc(32'h600); ret_valid = 1; irq_req = 1; rep_iter = 1; beat();
    // R10: enable clear
    clear_in(); set_pc(32'h700); ret_valid = 1; irq_req = 1; irq_en = 0; beat();
    // R1: faulting SS load gives no shadow
    clear_in(); set_pc(32'h800); ret_valid = 1; ret_loads_ss = 1; fault_req = 8'h10; beat();
    clear_in(); set_pc(32'h804); ret_valid = 1; irq_req = 1; beat();
    // R11: idle beat with requests
    clear_in(); irq_req = 1; trap_req = 1; beat();

    for (int n = 0; n < 1500; n++) begin
      clear_in();
      set_pc($urandom & 32'hFFFF_FFFC);
      ret_valid      = ($urandom % 8) != 0;
      fault_req      = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
      abort_req      = ($urandom % 12) == 0;
      trap_req       = ($urandom % 4) == 0;
      irq_req        = ($urandom % 2) == 0;
      irq_en         = ($urandom % 4) != 0;
      ret_loads_ss   = ($urandom % 5) == 0;
      rep_iter       = ($urandom % 4) == 0;
      ret_xfer_taken = ($urandom % 3) == 0;
      trap_vec = 8'($urandom); abort_vec = 8'($urandom); irq_vec = 8'($urandom);
      beat();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule